// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with I/O Bypass

This block sits between a CPU load/store port and a slower external memory bus. Both sides use request/response handshakes. Each line has one home index, so the cache is direct-mapped. A load that hits is answered from on-chip storage one cycle after it is accepted. A load that misses fetches its whole block from memory, one word at a time in ascending order. After that fetch the block is marked valid and the requested word is returned. Stores always go to memory. A store that hits also updates the cached word. A store that misses leaves the cache unchanged.

The top 256 MiB of the address space, 0xF0000000 through 0xFFFFFFFF, is treated as device space. Every access there is forwarded to memory exactly as issued and never allocates a line. A one-cycle flush pulse, raised for a fence, drops every valid bit at once. After a flush, every cached address is reloaded from memory on its next use.

The memory side must return exactly one response per accepted request, and no earlier than the cycle after acceptance. Block size (bytes, a power of two, at least 4) and block count (a power of two, at least 1) are parameters. Data words are 32 bits and addresses are 32 bits.

Top module: `dc_direct_cache`

## Requirements
- R1: A load outside the device window whose block is valid and whose tag matches gets `cpu_rsp_valid` exactly one cycle after acceptance, and issues no memory request.
- R2: A load miss outside the device window reads the whole block, from the block-aligned base upward in steps of 4 bytes. It then returns the word at the requested address. A later load to the same block hits.
- R3: Any access with `cpu_req_addr[31:28] == 4'hF` issues exactly one memory request, in the next cycle, with the same address, direction and data. It never allocates a line, so a repeated device load goes to memory again.
- R4: Every store issues exactly one memory write, in the next cycle, with its address and data. A store hit updates the cached word, so a later load returns the new data without memory traffic. A store miss allocates nothing, so a later load of that block misses.
- R5: While `cpu_flush` is high, `cpu_req_ready` is low. In the following cycle every line is invalid, so later loads refill from memory.
- R6: A memory response with `mem_rsp_err` set during a refill ends that refill. The CPU receives `cpu_rsp_err = 1` and the line stays invalid, so the next load refills again. An error on a device or store access is passed on in `cpu_rsp_err`.
- R7: A memory request, once raised, keeps `mem_req_valid` high and its address and direction stable until `mem_req_ready` is seen.
- R8: Each accepted request produces exactly one single-cycle `cpu_rsp_valid` pulse. `cpu_req_ready` stays low from acceptance until that response.
- R9: Two addresses with the same index bits and different tags evict each other.
- R10: After reset, `cpu_req_ready` is high, `cpu_rsp_valid` and `mem_req_valid` are low, and every line is invalid.
- R11: A flush that arrives while a refill is in progress keeps that refill from marking its line valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Cache can accept a CPU request this cycle |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address, word aligned |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Load data (zero for stores) |
| cpu_rsp_err | output | 1 | Memory reported an error for this access |
| cpu_flush | input | 1 | Invalidate the whole cache (fence) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_rdata | input | 32 | Memory read data |
| mem_rsp_err | input | 1 | Memory error flag |

## Verification
A wrong valid bit or tag shows up at the memory port on the next access to that index. Either an expected refill is missing, so the CPU gets stale data one cycle after acceptance, or a hit turns into a burst of block reads. A corrupted data word shows up as a wrong `cpu_rsp_rdata` on the first load that hits it. A bad refill counter shows up as out-of-order or repeated addresses within one burst. A flush that fails to clear a line is exposed by the very next load of that line, which then produces no memory reads.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    // Device space: top nibble all ones, never cached.
    function automatic logic in_dev_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ADDR_W-4] == 4'hF;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESP,
        ST_BUS_REQ,
        ST_BUS_WAIT,
        ST_FILL_REQ,
        ST_FILL_WAIT
    } dc_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } dc_req_t;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3,
    parameter int TAG_W      = 25
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush_i,
    input  logic [IDX_W-1:0]      lk_idx,
    input  logic [TAG_W-1:0]      lk_tag,
    output logic                  lk_hit,
    input  logic                  inval_en,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic [TAG_W-1:0]      set_tag,
    output logic [NUM_BLOCKS-1:0] valid_o
);

    logic [TAG_W-1:0] tag_q [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst || flush_i) begin
                valid_o[g] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                valid_o[g] <= 1'b1;
            end else if (inval_en && lk_idx == IDX_W'(g)) begin
                valid_o[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (set_en && set_idx == IDX_W'(g)) begin
                tag_q[g] <= set_tag;
            end
        end
    end

    always_comb begin
        lk_hit = valid_o[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
    parameter int NUM_BLOCKS = 8,
    parameter int WORDS      = 4,
    parameter int IDX_W      = 3,
    parameter int WSEL_W     = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [31:0]       rd_data
);

    localparam int DEPTH = NUM_BLOCKS * WORDS;

    logic [31:0] mem_q [DEPTH];

    function automatic int slot(input logic [IDX_W-1:0] i, input logic [WSEL_W-1:0] w);
        return int'(i) * WORDS + int'(w);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[slot(wr_idx, wr_wsel)] <= wr_data;
        end
    end

    always_comb begin
        rd_data = mem_q[slot(rd_idx, rd_wsel)];
    end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int BLOCK_BYTES = 16,
    parameter int NUM_BLOCKS  = 8,
    parameter int WORDS       = 4,
    parameter int OFF_W       = 4,
    parameter int IDX_BITS    = 3,
    parameter int IDX_W       = 3,
    parameter int WSEL_W      = 2,
    parameter int TAG_W       = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [31:0]       cpu_req_addr,
    input  logic [31:0]       cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [31:0]       cpu_rsp_rdata,
    output logic              cpu_rsp_err,
    input  logic              flush_i,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [31:0]       mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata,
    input  logic              mem_rsp_err,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_hit,
    output logic              inval_en,
    output logic              set_en,
    output logic [IDX_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  set_tag,
    output logic              dwr_en,
    output logic [IDX_W-1:0]  dwr_idx,
    output logic [WSEL_W-1:0] dwr_wsel,
    output logic [31:0]       dwr_data,
    output logic [WSEL_W-1:0] drd_wsel,
    input  logic [31:0]       drd_data
);

    localparam logic [31:0]       BASE_MASK = ~32'(BLOCK_BYTES - 1);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

    function automatic logic [IDX_W-1:0] idx_of(input logic [31:0] a);
        return IDX_W'((a >> OFF_W) & 32'(NUM_BLOCKS - 1));
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [31:0] a);
        return TAG_W'(a >> (OFF_W + IDX_BITS));
    endfunction

    function automatic logic [WSEL_W-1:0] wsel_of(input logic [31:0] a);
        return WSEL_W'((a >> 2) & 32'(WORDS - 1));
    endfunction

    dc_state_e         state_q, state_d;
    dc_req_t           req_q;
    logic [WSEL_W-1:0] cnt_q;
    logic [31:0]       rsp_data_q;
    logic              rsp_err_q;
    logic              kill_q;

    logic accept, dev, store_hit, fill_beat, fill_last;

    always_comb begin
        cpu_req_ready = (state_q == ST_IDLE) && !flush_i;
        accept        = cpu_req_valid && cpu_req_ready;
        dev           = in_dev_window(cpu_req_addr);
        lk_idx        = idx_of(cpu_req_addr);
        lk_tag        = tag_of(cpu_req_addr);
        drd_wsel      = wsel_of(cpu_req_addr);
        store_hit     = accept && cpu_req_we && !dev && lk_hit;
        fill_beat     = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
        fill_last     = fill_beat && !mem_rsp_err && (cnt_q == LAST_WORD);
        inval_en      = accept && !cpu_req_we && !dev && !lk_hit;
        set_en        = fill_last && !kill_q && !flush_i;
        set_idx       = idx_of(req_q.addr);
        set_tag       = tag_of(req_q.addr);
    end

    // Cache word write: store hit at acceptance, or a good refill beat.
    always_comb begin
        if (store_hit) begin
            dwr_en   = 1'b1;
            dwr_idx  = lk_idx;
            dwr_wsel = drd_wsel;
            dwr_data = cpu_req_wdata;
        end else begin
            dwr_en   = fill_beat && !mem_rsp_err;
            dwr_idx  = idx_of(req_q.addr);
            dwr_wsel = cnt_q;
            dwr_data = mem_rsp_rdata;
        end
    end

    always_comb begin
        mem_req_valid = (state_q == ST_BUS_REQ) || (state_q == ST_FILL_REQ);
        mem_req_we    = (state_q == ST_BUS_REQ) && req_q.we;
        mem_req_wdata = req_q.wdata;
        if (state_q == ST_FILL_REQ) begin
            mem_req_addr = (req_q.addr & BASE_MASK) | (32'(cnt_q) << 2);
        end else begin
            mem_req_addr = req_q.addr;
        end
        cpu_rsp_valid = (state_q == ST_RESP);
        cpu_rsp_rdata = rsp_data_q;
        cpu_rsp_err   = rsp_err_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (dev || cpu_req_we) state_d = ST_BUS_REQ;
                    else if (lk_hit)       state_d = ST_RESP;
                    else                   state_d = ST_FILL_REQ;
                end
            end
            ST_RESP:      state_d = ST_IDLE;
            ST_BUS_REQ:   if (mem_req_ready) state_d = ST_BUS_WAIT;
            ST_BUS_WAIT:  if (mem_rsp_valid) state_d = ST_RESP;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err || cnt_q == LAST_WORD) state_d = ST_RESP;
                    else                                   state_d = ST_FILL_REQ;
                end
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            cnt_q      <= '0;
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
            kill_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q.we    <= cpu_req_we;
                req_q.addr  <= cpu_req_addr;
                req_q.wdata <= cpu_req_wdata;
                cnt_q       <= '0;
                kill_q      <= 1'b0;
                rsp_data_q  <= drd_data;
                rsp_err_q   <= 1'b0;
            end else if (flush_i) begin
                kill_q <= 1'b1;
            end
            if (state_q == ST_BUS_WAIT && mem_rsp_valid) begin
                rsp_data_q <= req_q.we ? 32'h0 : mem_rsp_rdata;
                rsp_err_q  <= mem_rsp_err;
            end
            if (fill_beat) begin
                if (cnt_q == wsel_of(req_q.addr)) rsp_data_q <= mem_rsp_rdata;
                if (mem_rsp_err) rsp_err_q <= 1'b1;
                cnt_q <= cnt_q + WSEL_W'(1);
            end
        end
    end

endmodule

// File: rtl/dc_direct_cache.sv
module dc_direct_cache
    import dc_pkg::*;
#(
    parameter int BLOCK_BYTES = 16,
    parameter int NUM_BLOCKS  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic        cpu_req_we,
    input  logic [31:0] cpu_req_addr,
    input  logic [31:0] cpu_req_wdata,
    output logic        cpu_rsp_valid,
    output logic [31:0] cpu_rsp_rdata,
    output logic        cpu_rsp_err,
    input  logic        cpu_flush,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_we,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata,
    input  logic        mem_rsp_err
);

    localparam int WORDS    = BLOCK_BYTES / 4;
    localparam int OFF_W    = $clog2(BLOCK_BYTES);
    localparam int IDX_BITS = $clog2(NUM_BLOCKS);
    localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
    localparam int WSEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;

    logic [IDX_W-1:0]      lk_idx, set_idx, dwr_idx;
    logic [TAG_W-1:0]      lk_tag, set_tag;
    logic                  lk_hit, inval_en, set_en, dwr_en;
    logic [WSEL_W-1:0]     dwr_wsel, drd_wsel;
    logic [31:0]           dwr_data, drd_data;
    logic [NUM_BLOCKS-1:0] valid_vec;

    dc_ctrl #(
        .BLOCK_BYTES(BLOCK_BYTES), .NUM_BLOCKS(NUM_BLOCKS), .WORDS(WORDS),
        .OFF_W(OFF_W), .IDX_BITS(IDX_BITS), .IDX_W(IDX_W),
        .WSEL_W(WSEL_W), .TAG_W(TAG_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_err(cpu_rsp_err),
        .flush_i(cpu_flush),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .inval_en(inval_en), .set_en(set_en), .set_idx(set_idx), .set_tag(set_tag),
        .dwr_en(dwr_en), .dwr_idx(dwr_idx), .dwr_wsel(dwr_wsel), .dwr_data(dwr_data),
        .drd_wsel(drd_wsel), .drd_data(drd_data)
    );

    dc_tag_store #(
        .NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst(rst), .flush_i(cpu_flush),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .inval_en(inval_en), .set_en(set_en), .set_idx(set_idx), .set_tag(set_tag),
        .valid_o(valid_vec)
    );

    dc_data_store #(
        .NUM_BLOCKS(NUM_BLOCKS), .WORDS(WORDS), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_data (
        .clk(clk),
        .wr_en(dwr_en), .wr_idx(dwr_idx), .wr_wsel(dwr_wsel), .wr_data(dwr_data),
        .rd_idx(lk_idx), .rd_wsel(drd_wsel), .rd_data(drd_data)
    );

endmodule

// File: rtl/dc_direct_cache_chk.sv
module dc_direct_cache_chk #(
    parameter int NUM_BLOCKS = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cpu_req_valid,
    input logic                  cpu_req_ready,
    input logic                  cpu_req_we,
    input logic [31:0]           cpu_req_addr,
    input logic [31:0]           cpu_req_wdata,
    input logic                  cpu_rsp_valid,
    input logic                  cpu_flush,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic                  mem_req_we,
    input logic [31:0]           mem_req_addr,
    input logic [31:0]           mem_req_wdata,
    input logic [NUM_BLOCKS-1:0] valid_vec
);

    logic taken;
    assign taken = cpu_req_valid && cpu_req_ready;

    assert_dev_forward_R3: assert property (@(posedge clk) disable iff (rst)
        taken && cpu_req_addr[31:28] == 4'hF |=>
        mem_req_valid && mem_req_addr == $past(cpu_req_addr) && mem_req_we == $past(cpu_req_we));

    assert_store_through_R4: assert property (@(posedge clk) disable iff (rst)
        taken && cpu_req_we |=>
        mem_req_valid && mem_req_we && mem_req_addr == $past(cpu_req_addr)
        && mem_req_wdata == $past(cpu_req_wdata));

    assert_flush_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_flush |-> !cpu_req_ready);

    assert_flush_clears_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_flush |=> valid_vec == '0);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
        mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    assert_single_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        taken |=> !cpu_req_ready);

    assert_no_early_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |-> !cpu_req_ready);

endmodule

bind dc_direct_cache dc_direct_cache_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_flush(cpu_flush),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .valid_vec(valid_vec)
);

// File: tb/sim_dc_direct_cache.sv
module sim_dc_direct_cache;

    localparam int CLK_PERIOD = 10;
    localparam int BLK        = 16;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t TABLE [12] = '{
        '{1'b0, 32'h0000_0100, 32'h0,          4'd4, 4'd0, 8'd2},
        '{1'b0, 32'h0000_0104, 32'h0,          4'd0, 4'd0, 8'd1},
        '{1'b1, 32'h0000_0108, 32'hCAFE_0108,  4'd0, 4'd1, 8'd4},
        '{1'b0, 32'h0000_0108, 32'h0,          4'd0, 4'd0, 8'd4},
        '{1'b0, 32'h0000_0500, 32'h0,          4'd4, 4'd0, 8'd9},
        '{1'b0, 32'h0000_010C, 32'h0,          4'd4, 4'd0, 8'd9},
        '{1'b1, 32'h0000_0240, 32'hBEEF_0240,  4'd0, 4'd1, 8'd4},
        '{1'b0, 32'h0000_0248, 32'h0,          4'd4, 4'd0, 8'd4},
        '{1'b0, 32'h0000_0244, 32'h0,          4'd0, 4'd0, 8'd1},
        '{1'b0, 32'hF000_0020, 32'h0,          4'd1, 4'd0, 8'd3},
        '{1'b0, 32'hF000_0020, 32'h0,          4'd1, 4'd0, 8'd3},
        '{1'b1, 32'hF000_0024, 32'h1234_5678,  4'd0, 4'd1, 8'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_we = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        cpu_rsp_err;
    logic        cpu_flush = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        mem_rsp_err;

    // memory model controls
    logic        stall = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    logic [31:0] mem_arr [1024];
    logic [31:0] ref_arr [1024];
    logic [31:0] rd_log [8];
    int          rd_cnt, wr_cnt, cyc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit busy_ok, single_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_direct_cache #(.BLOCK_BYTES(BLK), .NUM_BLOCKS(8)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_err(cpu_rsp_err),
        .cpu_flush(cpu_flush),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err)
    );

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem_arr[i] = 32'h1000_0000 + i * 32'h0001_0003;
            ref_arr[i] = 32'h1000_0000 + i * 32'h0001_0003;
        end
    end

    assign mem_req_ready = !stall || cyc[0];

    // Memory model: one response, one cycle after acceptance.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
            mem_rsp_err   <= 1'b0;
            rd_cnt        <= 0;
            wr_cnt        <= 0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_err   <= err_en && (mem_req_addr == err_addr);
                mem_rsp_rdata <= mem_arr[mem_req_addr[11:2]];
                if (mem_req_we) begin
                    mem_arr[mem_req_addr[11:2]] <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_log[rd_cnt[2:0]] <= mem_req_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er, output int lat);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!cpu_rsp_valid && lat < 400) begin
            if (cpu_req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (cpu_req_ready) busy_ok = 1'b0;
        rd = cpu_rsp_rdata;
        er = cpu_rsp_err;
        @(negedge clk);
        single_ok = !cpu_rsp_valid;
    endtask

    task automatic pulse_flush(input bit check_ready);
        @(negedge clk);
        cpu_flush = 1'b1;
        #1;
        if (check_ready) chk(!cpu_req_ready, "R5 ready low in flush cycle", 32'(cpu_req_ready), 32'h0);
        @(negedge clk);
        cpu_flush = 1'b0;
    endtask

    task automatic check_burst(input int c0, input logic [31:0] addr, input string req);
        logic [31:0] base;
        base = addr & ~32'(BLK - 1);
        for (int k = 0; k < BLK / 4; k++) begin
            chk(rd_log[(c0 + k) % 8] == base + 32'(4 * k), req, rd_log[(c0 + k) % 8], base + 32'(4 * k));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          lat, r0, w0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(cpu_req_ready == 1'b1, "R10 ready after reset", 32'(cpu_req_ready), 32'h1);
        chk(cpu_rsp_valid == 1'b0, "R10 no response after reset", 32'(cpu_rsp_valid), 32'h0);
        chk(mem_req_valid == 1'b0, "R10 no memory request after reset", 32'(mem_req_valid), 32'h0);

        // Table walk: R1 R2 R3 R4 R9
        for (int v = 0; v < 12; v++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", TABLE[v].req, v);
            r0 = rd_cnt;
            w0 = wr_cnt;
            access(TABLE[v].we, TABLE[v].addr, TABLE[v].wdata, rd, er, lat);
            if (TABLE[v].we) ref_arr[TABLE[v].addr[11:2]] = TABLE[v].wdata;
            else chk(rd == ref_arr[TABLE[v].addr[11:2]], {tag, " data"}, rd, ref_arr[TABLE[v].addr[11:2]]);
            chk(er == 1'b0, {tag, " err"}, 32'(er), 32'h0);
            chk(rd_cnt - r0 == int'(TABLE[v].nrd), {tag, " reads"}, 32'(rd_cnt - r0), 32'(TABLE[v].nrd));
            chk(wr_cnt - w0 == int'(TABLE[v].nwr), {tag, " writes"}, 32'(wr_cnt - w0), 32'(TABLE[v].nwr));
            chk(busy_ok && single_ok, {tag, " R8 handshake"}, 32'({busy_ok, single_ok}), 32'h3);
            if (TABLE[v].nrd == 4'd0 && TABLE[v].nwr == 4'd0)
                chk(lat == 1, {tag, " R1 hit latency"}, 32'(lat), 32'h1);
            if (TABLE[v].nrd == 4'd4) check_burst(r0, TABLE[v].addr, {tag, " R2 ascending refill"});
        end

        // R5 flush invalidates cached block
        r0 = rd_cnt;
        access(1'b0, 32'h104, 32'h0, rd, er, lat);
        chk(rd_cnt == r0, "R5 pre-flush hit", 32'(rd_cnt - r0), 32'h0);
        pulse_flush(1'b1);
        r0 = rd_cnt;
        access(1'b0, 32'h104, 32'h0, rd, er, lat);
        chk(rd_cnt - r0 == 4, "R5 refill after flush", 32'(rd_cnt - r0), 32'h4);
        chk(rd == ref_arr[32'h104 >> 2], "R5 data after flush", rd, ref_arr[32'h104 >> 2]);

        // R6 refill error leaves line invalid
        err_en = 1'b1;
        err_addr = 32'h308;
        access(1'b0, 32'h300, 32'h0, rd, er, lat);
        chk(er == 1'b1, "R6 refill error reported", 32'(er), 32'h1);
        err_en = 1'b0;
        r0 = rd_cnt;
        access(1'b0, 32'h300, 32'h0, rd, er, lat);
        chk(rd_cnt - r0 == 4, "R6 line invalid after error", 32'(rd_cnt - r0), 32'h4);
        chk(er == 1'b0 && rd == ref_arr[32'h300 >> 2], "R6 clean reload", rd, ref_arr[32'h300 >> 2]);
        err_en = 1'b1;
        err_addr = 32'hF000_0040;
        access(1'b0, 32'hF000_0040, 32'h0, rd, er, lat);
        chk(er == 1'b1, "R6 device error reported", 32'(er), 32'h1);
        err_en = 1'b0;

        // R7 stalled memory: refill still correct and ordered
        stall = 1'b1;
        r0 = rd_cnt;
        access(1'b0, 32'h70C, 32'h0, rd, er, lat);
        chk(rd == ref_arr[32'h70C >> 2], "R7 data under stall", rd, ref_arr[32'h70C >> 2]);
        check_burst(r0, 32'h70C, "R7 ordered refill under stall");

        // R11 flush during refill keeps line invalid
        fork
            access(1'b0, 32'h904, 32'h0, rd, er, lat);
            begin
                repeat (4) @(negedge clk);
                pulse_flush(1'b0);
            end
        join
        chk(rd == ref_arr[32'h904 >> 2], "R11 data of interrupted refill", rd, ref_arr[32'h904 >> 2]);
        stall = 1'b0;
        r0 = rd_cnt;
        access(1'b0, 32'h904, 32'h0, rd, er, lat);
        chk(rd_cnt - r0 == 4, "R11 line not valid after flush in refill", 32'(rd_cnt - r0), 32'h4);

        finish_run();
    end

endmodule